// File: doc/BRIEF.md
# Banked Word Memory with SEC-DED Protection

This block is a word-addressed memory made of equal banks, each guarded word by word with a single-error-correcting, double-error-detecting code. A master issues one request per cycle: a read or a write of a 32-bit word at a byte address. The block splits the address into a bank index and a word offset. On a write it computes seven check bits and stores a 39-bit codeword. On a read it decodes the stored codeword. It corrects any single flipped bit and flags any double flip as uncorrectable. The response comes exactly one cycle after the request.

A per-bank power-gate register lets software switch off banks it does not need. A request aimed at a switched-off bank, or at a bank index past the last bank, gets an error response and does not touch the memory. Two sticky status bits record these two kinds of misdirected access. Two saturating counters record corrected and uncorrectable read events. The word address of the most recent ECC fault is held for diagnosis.

The memory array is a behavioural model. It keeps the low `MODEL_WORDS` words of every bank, and the full bank stride is still used when the address is decoded. A diagnostic flip mask is applied to the codeword as it is written, so that stored errors can be created on purpose.

Top module: `ecc_bank_sram`

## Requirements
- R1: The byte address splits into bank = addr[19:15] and word offset = addr[14:2]; addr[1:0] are ignored, and equal offsets in different banks hold independent words.
- R2: A read of a word written with an all-zero flip mask returns the written data with rsp_err, ecc_corr and ecc_uncorr all low.
- R3: When exactly one of the 39 stored bits (bit index 0..38 of inj_flip) was flipped, a read returns the original data with ecc_corr high and ecc_uncorr low.
- R4: When exactly two stored bits were flipped, a read raises ecc_uncorr, leaves ecc_corr and rsp_err low, and returns rdata = 0.
- R5: A request to bank index 20..31 gets rsp_err high and rdata = 0, writes nothing, and sets sts_bad_bank.
- R6: A request to a gated bank gets rsp_err high and rdata = 0, leaves that bank's contents unchanged, and sets sts_gate_hit.
- R7: gate_wr loads gate_val into the gate register, where bit b high means bank b is off. The register resets to all zeros (all banks on), is shown on gate_state, and gating one bank does not affect the other banks.
- R8: cnt_corr and cnt_uncorr count corrected and uncorrectable read responses, one per event, and saturate at 16'hFFFF.
- R9: fault_addr holds the word address (addr with bits [1:0] zero) of the latest read with ecc_corr or ecc_uncorr.
- R10: Every request produces exactly one response with rsp_valid high in the next cycle, and rsp_valid stays low otherwise. Writes return rdata = 0.
- R11: sts_clr clears both counters and both status bits. A status event in the same cycle wins over the clear.
- R12: A clean rewrite of a word that held an uncorrectable error stores fresh check bits, and the next read is error-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Byte address |
| wdata | input | 32 | Write data |
| inj_flip | input | 39 | Diagnostic XOR mask applied to the stored codeword on write |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Access refused (gated or invalid bank) |
| rdata | output | 32 | Read data, zero unless a clean or corrected read |
| ecc_corr | output | 1 | Read response carried a corrected single-bit error |
| ecc_uncorr | output | 1 | Read response carried an uncorrectable error |
| gate_wr | input | 1 | Load the gate register |
| gate_val | input | 20 | New gate register value, bit per bank |
| gate_state | output | 20 | Current gate register |
| sts_clr | input | 1 | Clear counters and status bits |
| sts_gate_hit | output | 1 | Sticky: a gated bank was accessed |
| sts_bad_bank | output | 1 | Sticky: a nonexistent bank was accessed |
| cnt_corr | output | 16 | Saturating corrected-error count |
| cnt_uncorr | output | 16 | Saturating uncorrectable-error count |
| fault_addr | output | 20 | Word address of the last ECC fault |

## Verification
A wrong check-bit position or syndrome mapping shows at the ports on the first read of a word that carries a flipped bit. That read then returns wrong data, or raises the wrong one of the two ECC flags. A wrong bank or offset decode aliases two words, and the read-back right after them returns the other word's data. A gate register or status bit stuck at the wrong value changes rsp_err on the next access to that bank. Counter or fault-address faults appear a few idle cycles after the event, or, for saturation, once the count reaches its top.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CW_W   = DATA_W + HAM_W + 1;   // 39-bit stored word
    localparam int CNT_W  = 16;

    typedef logic [CW_W-1:0] cw_t;

    typedef enum logic [1:0] {
        RSP_WRITE,
        RSP_READ,
        RSP_GATED,
        RSP_BADBANK
    } rsp_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              uncorr;
    } dec_res_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Codeword position 0 holds overall parity, powers of two hold Hamming bits.
    function automatic cw_t ecc_encode(input logic [DATA_W-1:0] d);
        cw_t cw;
        int  k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < HAM_W; j++) begin
            logic s;
            s = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> j) & 1) != 0) s ^= cw[p];
            end
            cw[1 << j] = s;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic dec_res_t ecc_decode(input cw_t cw);
        dec_res_t          r;
        logic [HAM_W-1:0]  syn;
        logic              par;
        cw_t               fx;
        int                k;
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn ^= HAM_W'(p);
        end
        par      = ^cw;
        fx       = cw;
        r.corr   = 1'b0;
        r.uncorr = 1'b0;
        if (par) begin
            if (int'(syn) < CW_W) begin
                fx[syn]  = ~fx[syn];
                r.corr   = 1'b1;
            end else begin
                r.uncorr = 1'b1;
            end
        end else if (syn != '0) begin
            r.uncorr = 1'b1;
        end
        r.data = '0;
        k      = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                r.data[k] = fx[p];
                k++;
            end
        end
        if (r.uncorr) r.data = '0;
        return r;
    endfunction

endpackage

// File: rtl/ecc_addr_split.sv
module ecc_addr_split #(
    parameter int ADDR_W    = 20,
    parameter int NUM_BANKS = 20,
    parameter int OFF_W     = 13,
    localparam int BANK_W   = ADDR_W - 2 - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  off,
    output logic              bank_ok
);
    logic unused_lo;

    assign off       = addr[OFF_W+1:2];
    assign bank      = addr[ADDR_W-1:OFF_W+2];
    assign bank_ok   = int'(bank) < NUM_BANKS;
    assign unused_lo = ^addr[1:0];
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
    import ecc_sram_pkg::*;
#(
    parameter int NUM_BANKS   = 20,
    parameter int MODEL_WORDS = 64,
    parameter int BANK_W      = 5,
    parameter int OFF_W       = 13,
    localparam int MW_W       = $clog2(MODEL_WORDS),
    localparam int DEPTH      = NUM_BANKS * MODEL_WORDS,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  off,
    input  cw_t               wr_word,
    output cw_t               rd_word
);
    cw_t              mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    assign idx       = IDX_W'(int'(bank) * MODEL_WORDS + int'(off[MW_W-1:0]));
    assign unused_hi = ^off[OFF_W-1:MW_W];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wr_word;
        if (rd_en) rd_word  <= mem[idx];
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ev_corr,
    input  logic              ev_uncorr,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_gate,
    input  logic              ev_bad,
    output logic [CNT_W-1:0]  cnt_corr,
    output logic [CNT_W-1:0]  cnt_uncorr,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              sts_gate_hit,
    output logic              sts_bad_bank
);
    logic [1:0]             ev;
    logic [1:0][CNT_W-1:0]  cnt;

    assign ev = {ev_uncorr, ev_corr};

    for (genvar i = 0; i < 2; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr)                   cnt[i] <= '0;
            else if (ev[i] && cnt[i] != '1)   cnt[i] <= cnt[i] + 1'b1;
        end
    end

    assign cnt_corr   = cnt[0];
    assign cnt_uncorr = cnt[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_addr   <= '0;
            sts_gate_hit <= 1'b0;
            sts_bad_bank <= 1'b0;
        end else begin
            if (ev_corr || ev_uncorr) fault_addr <= ev_addr;
            if (ev_gate)      sts_gate_hit <= 1'b1;
            else if (clr)     sts_gate_hit <= 1'b0;
            if (ev_bad)       sts_bad_bank <= 1'b1;
            else if (clr)     sts_bad_bank <= 1'b0;
        end
    end
endmodule

// File: rtl/ecc_bank_sram.sv
module ecc_bank_sram
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int NUM_BANKS   = 20,
    parameter int BANK_BYTES  = 32768,
    parameter int MODEL_WORDS = 64,
    localparam int OFF_W      = $clog2(BANK_BYTES / 4),
    localparam int BANK_W     = ADDR_W - 2 - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CW_W-1:0]      inj_flip,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ecc_corr,
    output logic                 ecc_uncorr,
    input  logic                 gate_wr,
    input  logic [NUM_BANKS-1:0] gate_val,
    output logic [NUM_BANKS-1:0] gate_state,
    input  logic                 sts_clr,
    output logic                 sts_gate_hit,
    output logic                 sts_bad_bank,
    output logic [CNT_W-1:0]     cnt_corr,
    output logic [CNT_W-1:0]     cnt_uncorr,
    output logic [ADDR_W-1:0]    fault_addr
);
    logic [BANK_W-1:0]    bank;
    logic [OFF_W-1:0]     off;
    logic                 bank_ok;
    logic                 gated;
    logic                 wr_en;
    logic                 rd_en;
    logic [NUM_BANKS-1:0] gate_q;
    logic                 rsp_valid_q;
    rsp_kind_e            rsp_kind_q;
    logic [ADDR_W-1:0]    rsp_addr_q;
    cw_t                  rd_word;
    dec_res_t             dec;
    logic                 is_rd;

    ecc_addr_split #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .OFF_W(OFF_W)
    ) u_split (
        .addr(addr), .bank(bank), .off(off), .bank_ok(bank_ok)
    );

    assign gated = bank_ok && gate_q[bank];
    assign wr_en = req && we  && bank_ok && !gated;
    assign rd_en = req && !we && bank_ok && !gated;

    ecc_word_store #(
        .NUM_BANKS(NUM_BANKS), .MODEL_WORDS(MODEL_WORDS),
        .BANK_W(BANK_W), .OFF_W(OFF_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .rd_en(rd_en), .bank(bank), .off(off),
        .wr_word(ecc_encode(wdata) ^ inj_flip), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_kind_q  <= RSP_WRITE;
            rsp_addr_q  <= '0;
        end else begin
            if (gate_wr) gate_q <= gate_val;
            rsp_valid_q <= req;
            if (req) begin
                rsp_addr_q <= {addr[ADDR_W-1:2], 2'b00};
                if (!bank_ok)   rsp_kind_q <= RSP_BADBANK;
                else if (gated) rsp_kind_q <= RSP_GATED;
                else if (we)    rsp_kind_q <= RSP_WRITE;
                else            rsp_kind_q <= RSP_READ;
            end
        end
    end

    assign dec        = ecc_decode(rd_word);
    assign is_rd      = rsp_valid_q && rsp_kind_q == RSP_READ;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_valid_q &&
                        (rsp_kind_q == RSP_GATED || rsp_kind_q == RSP_BADBANK);
    assign rdata      = is_rd ? dec.data : '0;
    assign ecc_corr   = is_rd && dec.corr;
    assign ecc_uncorr = is_rd && dec.uncorr;
    assign gate_state = gate_q;

    ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst(rst), .clr(sts_clr),
        .ev_corr(ecc_corr), .ev_uncorr(ecc_uncorr), .ev_addr(rsp_addr_q),
        .ev_gate(req && gated), .ev_bad(req && !bank_ok),
        .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr), .fault_addr(fault_addr),
        .sts_gate_hit(sts_gate_hit), .sts_bad_bank(sts_bad_bank)
    );
endmodule

// File: rtl/ecc_bank_sram_chk.sv
module ecc_bank_sram_chk
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rdata,
    input logic              ecc_corr,
    input logic              ecc_uncorr,
    input logic              sts_clr,
    input logic              sts_gate_hit,
    input logic              sts_bad_bank,
    input logic [CNT_W-1:0]  cnt_corr,
    input logic [CNT_W-1:0]  cnt_uncorr
);
    // R10: one response per request, one cycle later
    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);
    p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rsp_valid);
    // R10: flags only accompany a response
    p_flags_need_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_err && !ecc_corr && !ecc_uncorr));
    // R3/R4: the two ECC outcomes exclude each other
    p_ecc_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(ecc_corr && ecc_uncorr));
    // R4: uncorrectable reads return zero data
    p_uncorr_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ecc_uncorr |-> rdata == '0);
    // R5/R6: refused accesses carry no data and no ECC flag, and are recorded
    p_err_clean_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rdata == '0 && !ecc_corr && !ecc_uncorr));
    p_err_status_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (sts_gate_hit || sts_bad_bank));
    // R8: counters never drop without a clear, and step by one per event
    p_corr_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !sts_clr |=> cnt_corr >= $past(cnt_corr));
    p_uncorr_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !sts_clr |=> cnt_uncorr >= $past(cnt_uncorr));
    p_corr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (ecc_corr && !sts_clr && cnt_corr != '1) |=>
            cnt_corr == CNT_W'($past(cnt_corr) + 1'b1));
    // R11: clear zeroes the counters
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        sts_clr |=> (cnt_corr == '0 && cnt_uncorr == '0));
endmodule

bind ecc_bank_sram ecc_bank_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req(req), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rdata(rdata), .ecc_corr(ecc_corr),
    .ecc_uncorr(ecc_uncorr), .sts_clr(sts_clr),
    .sts_gate_hit(sts_gate_hit), .sts_bad_bank(sts_bad_bank),
    .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr)
);

// File: tb/test_ecc_bank_sram.sv
module test_ecc_bank_sram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we  = 1'b0;
    logic [19:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [38:0] inj_flip = '0;
    logic        rsp_valid, rsp_err, ecc_corr, ecc_uncorr;
    logic [31:0] rdata;
    logic        gate_wr = 1'b0;
    logic [19:0] gate_val = '0;
    logic [19:0] gate_state;
    logic        sts_clr = 1'b0;
    logic        sts_gate_hit, sts_bad_bank;
    logic [15:0] cnt_corr, cnt_uncorr;
    logic [19:0] fault_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] d;
        bit          err;
        bit          corr;
        bit          unc;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    ecc_bank_sram i_ecc_bank_sram (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .inj_flip(inj_flip), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rdata(rdata), .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr),
        .gate_wr(gate_wr), .gate_val(gate_val), .gate_state(gate_state),
        .sts_clr(sts_clr), .sts_gate_hit(sts_gate_hit),
        .sts_bad_bank(sts_bad_bank), .cnt_corr(cnt_corr),
        .cnt_uncorr(cnt_uncorr), .fault_addr(fault_addr)
    );

    function automatic logic [19:0] mk(input int b, input int o);
        return {5'(b), 13'(o), 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, expected response pushed to the scoreboard
    task automatic op(input bit w, input logic [19:0] a, input logic [31:0] d,
                      input logic [38:0] f, input exp_t e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; inj_flip = f;
        q.push_back(e);
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d,
                      input logic [38:0] f, input bit err, input string tag);
        exp_t e;
        e.d = '0; e.err = err; e.corr = 1'b0; e.unc = 1'b0; e.tag = tag;
        op(1'b1, a, d, f, e);
    endtask

    task automatic rd(input logic [19:0] a, input logic [31:0] d, input bit err,
                      input bit corr, input bit unc, input string tag);
        exp_t e;
        e.d = d; e.err = err; e.corr = corr; e.unc = unc; e.tag = tag;
        op(1'b0, a, '0, '0, e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req = 1'b0; we = 1'b0; inj_flip = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    task automatic set_gate(input logic [19:0] v);
        @(negedge clk); gate_wr = 1'b1; gate_val = v;
        @(negedge clk); gate_wr = 1'b0;
    endtask

    // Monitor: compare every response against the scoreboard head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rdata !== e.d || rsp_err !== e.err ||
                    ecc_corr !== e.corr || ecc_uncorr !== e.unc) begin
                    errors++;
                    $display("FAIL %s actual d=%h err=%b c=%b u=%b expected d=%h err=%b c=%b u=%b",
                             e.tag, rdata, rsp_err, ecc_corr, ecc_uncorr,
                             e.d, e.err, e.corr, e.unc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk("R7 gate reset", 32'(gate_state), 32'h0);
        chk("R10 idle rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R8 reset cnt_corr", 32'(cnt_corr), 32'h0);
        chk("R11 reset status", 32'({sts_gate_hit, sts_bad_bank}), 32'h0);

        // R2 plain write / read
        wr(mk(0, 0), 32'hDEAD_BEEF, '0, 0, "R2 wr");
        wr(mk(0, 1), 32'h0000_0000, '0, 0, "R2 wr");
        wr(mk(0, 2), 32'hFFFF_FFFF, '0, 0, "R2 wr");
        wr(mk(19, 63), 32'h1234_5678, '0, 0, "R2 wr");
        rd(mk(0, 0), 32'hDEAD_BEEF, 0, 0, 0, "R2 rd");
        rd(mk(0, 1), 32'h0000_0000, 0, 0, 0, "R2 rd");
        rd(mk(0, 2), 32'hFFFF_FFFF, 0, 0, 0, "R2 rd");
        rd(mk(19, 63), 32'h1234_5678, 0, 0, 0, "R2 rd");

        // R1 decode: same offset in two banks, low address bits ignored
        wr(mk(1, 5), 32'hAAAA_0001, '0, 0, "R1 wr");
        wr(mk(2, 5), 32'hBBBB_0002, '0, 0, "R1 wr");
        rd(mk(1, 5) | 20'h3, 32'hAAAA_0001, 0, 0, 0, "R1 rd bank1");
        rd(mk(2, 5) | 20'h1, 32'hBBBB_0002, 0, 0, 0, "R1 rd bank2");

        // R3 single flip in every stored bit position
        for (int i = 0; i < 39; i++)
            wr(mk(3, i), 32'hC0DE_0000 ^ 32'(i * 32'h0101_0101), 39'(1) << i, 0, "R3 wr");
        for (int i = 0; i < 39; i++)
            rd(mk(3, i), 32'hC0DE_0000 ^ 32'(i * 32'h0101_0101), 0, 1, 0, "R3 rd");
        idle(3);
        chk("R8 cnt_corr 39", 32'(cnt_corr), 32'd39);
        chk("R9 fault_addr", 32'(fault_addr), 32'(mk(3, 38)));

        // R4 double flips
        for (int i = 0; i < 5; i++)
            wr(mk(4, i), 32'h5A5A_5A5A, (39'(3) << (i * 7)), 0, "R4 wr");
        for (int i = 0; i < 5; i++)
            rd(mk(4, i), 32'h0, 0, 0, 1, "R4 rd");
        idle(3);
        chk("R8 cnt_uncorr 5", 32'(cnt_uncorr), 32'd5);
        chk("R9 fault_addr uncorr", 32'(fault_addr), 32'(mk(4, 4)));

        // R12 clean rewrite restores the word
        wr(mk(4, 0), 32'h600D_600D, '0, 0, "R12 wr");
        rd(mk(4, 0), 32'h600D_600D, 0, 0, 0, "R12 rd");

        // R5 nonexistent banks
        chk("R5 status before", 32'(sts_bad_bank), 32'h0);
        wr(mk(25, 0), 32'h0BAD_0BAD, '0, 1, "R5 wr");
        rd(mk(25, 0), 32'h0, 1, 0, 0, "R5 rd");
        rd(mk(31, 1), 32'h0, 1, 0, 0, "R5 rd");
        rd(mk(0, 0), 32'hDEAD_BEEF, 0, 0, 0, "R5 no side effect");
        idle(2);
        chk("R5 sts_bad_bank", 32'(sts_bad_bank), 32'h1);

        // R11 clear
        pulse_clr();
        chk("R11 cnt_corr cleared", 32'(cnt_corr), 32'h0);
        chk("R11 cnt_uncorr cleared", 32'(cnt_uncorr), 32'h0);
        chk("R11 status cleared", 32'({sts_gate_hit, sts_bad_bank}), 32'h0);

        // R6 / R7 gating
        wr(mk(6, 1), 32'h1111_6666, '0, 0, "R6 wr");
        wr(mk(7, 1), 32'h2222_7777, '0, 0, "R7 wr");
        idle(1);
        set_gate(20'h0_0040);
        chk("R7 gate_state", 32'(gate_state), 32'h0_0040);
        wr(mk(6, 1), 32'hFFFF_0000, '0, 1, "R6 gated wr");
        rd(mk(6, 1), 32'h0, 1, 0, 0, "R6 gated rd");
        rd(mk(7, 1), 32'h2222_7777, 0, 0, 0, "R7 neighbour bank");
        idle(2);
        chk("R6 sts_gate_hit", 32'(sts_gate_hit), 32'h1);
        chk("R6 sts_bad_bank untouched", 32'(sts_bad_bank), 32'h0);
        set_gate(20'h0);
        rd(mk(6, 1), 32'h1111_6666, 0, 0, 0, "R6 content kept");

        // R8 saturation
        wr(mk(8, 0), 32'h7777_8888, 39'(1) << 20, 0, "R8 wr");
        idle(1);
        pulse_clr();
        for (int i = 0; i < 65540; i++)
            rd(mk(8, 0), 32'h7777_8888, 0, 1, 0, "R8 rd");
        idle(3);
        chk("R8 cnt_corr saturated", 32'(cnt_corr), 32'hFFFF);
        chk("R10 scoreboard drained", 32'(q.size()), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule